// File: doc/BRIEF.md
# Sample-Paced Hardware Watchdog

This block guards the audio processing path against stalls. A down-counter is loaded with a programmed start value and decrements once per clock while the watchdog is enabled. When the count reaches zero it freezes there and raises a reset request for the system.

The counter is not refilled by a software kick. Instead, a small phase counter counts the per-sample strobe of the audio path. Every sixteenth strobe refills the down-counter with the start value. As long as samples keep flowing fast enough, the count never reaches zero. If the path stops producing samples, the refills stop and the watchdog trips.

Two configuration bits control the block: an enable and an active-high refill inhibit. In the configuration register these sit at bit 8 and bit 9; here they arrive as direct inputs. Setting the inhibit lets the count run down to zero regardless of sample activity.

Top module: `sample_watchdog`

## Requirements
- R1: While `wd_enable` is low, the count is held at `start_count`, the sample phase is held at zero and `reset_req` is low.
- R2: While enabled, the count starts from `start_count` on the first enabled clock edge and decreases by one on every clock edge.
- R3: `reset_req` is high exactly while the watchdog is enabled and the count is zero. Once the count reaches zero it stays at zero, and neither strobes nor refill events release it until `wd_enable` goes low.
- R4: While enabled, each clock edge with `sample_tick` high advances the sample phase by one, modulo 16. A strobe taken while the phase is 15 (the sixteenth strobe) is a refill event, which loads `start_count` into the count when `no_refill` is low.
- R5: While `no_refill` is high, no refill takes place, and the count runs down to zero even with continuous strobes. The sample phase still advances.
- R6: When a refill event and a decrement fall on the same edge with a nonzero count, the refill wins: the count becomes `start_count`.
- R7: Dropping `wd_enable` for one edge restarts the sample phase. After re-enabling, a full sixteen strobes are needed before the next refill.
- R8: A `start_count` of zero makes `reset_req` rise right after the first enabled clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wd_enable | input | 1 | Watchdog enable (configuration bit 8) |
| no_refill | input | 1 | Inhibits sample-paced refill when high (configuration bit 9) |
| start_count | input | CNT_W | Programmed initial / refill count |
| sample_tick | input | 1 | One-cycle strobe per audio sample |
| reset_req | output | 1 | System reset request, level |

## Verification
The bench builds the block with an 8-bit count and the default 16-strobe refill interval. With these values, every start count from 0 to 20 can be swept against strobe periods of one, two and three cycles, with and without the inhibit. This puts both sides of the refill boundary within reach: a start count of 15 trips before the sixteenth back-to-back strobe arrives, while 16 is rescued by a refill that collides with the last decrement. A further directed run drops the enable in mid-phase to show that the phase restarts.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Decoded configuration bits of the watchdog
    typedef struct packed {
        logic enable;
        logic no_refill;
    } wdt_ctrl_t;

    // Refill interval expressed as phase counter width (2**4 = 16 samples)
    localparam int unsigned WDT_PHASE_W_DEF = 4;

endpackage

// File: rtl/wdt_phase.sv
module wdt_phase #(
    parameter int unsigned PHASE_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic tick_i,
    output logic wrap_o
);
    localparam logic [PHASE_W-1:0] LAST = {PHASE_W{1'b1}};

    typedef struct packed {
        logic [PHASE_W-1:0] phase;
    } phase_st_t;

    phase_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!enable_i) begin
            st_d.phase = '0;
        end else if (tick_i) begin
            st_d.phase = st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wrap_o = enable_i && tick_i && (st_q.phase == LAST);

    // R7: disabling clears the phase
    assert_phase_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (st_q.phase == '0));

    // R4: each enabled strobe advances the phase
    assert_phase_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && tick_i) |=> (st_q.phase == PHASE_W'($past(st_q.phase) + 1'b1)));

    // R4: no strobe, no movement
    assert_phase_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && !tick_i) |=> $stable(st_q.phase));

endmodule

// File: rtl/wdt_down.sv
module wdt_down #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             refill_i,
    input  logic [CNT_W-1:0] init_i,
    output logic             zero_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } down_st_t;

    down_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!enable_i) begin
            st_d.cnt = init_i;
        end else if (st_q.cnt != '0) begin
            if (refill_i) st_d.cnt = init_i;
            else          st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign zero_o = (st_q.cnt == '0);

    // R1: disabled count follows the start value
    assert_hold_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (st_q.cnt == $past(init_i)));

    // R2: plain decrement
    assert_decrement_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && (st_q.cnt != '0) && !refill_i) |=> (st_q.cnt == CNT_W'($past(st_q.cnt) - 1'b1)));

    // R3: zero is sticky while enabled
    assert_zero_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && (st_q.cnt == '0)) |=> (st_q.cnt == '0));

    // R6: refill beats decrement
    assert_refill_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && (st_q.cnt != '0) && refill_i) |=> (st_q.cnt == $past(init_i)));

endmodule

// File: rtl/sample_watchdog.sv
module sample_watchdog #(
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned PHASE_W = wdt_pkg::WDT_PHASE_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wd_enable,
    input  logic             no_refill,
    input  logic [CNT_W-1:0] start_count,
    input  logic             sample_tick,
    output logic             reset_req
);
    import wdt_pkg::*;

    typedef struct packed {
        logic armed;
    } top_st_t;

    wdt_ctrl_t ctrl;
    top_st_t   st_d, st_q;
    logic      wrap, refill, at_zero;

    assign ctrl.enable    = wd_enable;
    assign ctrl.no_refill = no_refill;

    wdt_phase #(.PHASE_W(PHASE_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (ctrl.enable),
        .tick_i   (sample_tick),
        .wrap_o   (wrap)
    );

    assign refill = wrap && !ctrl.no_refill;

    wdt_down #(.CNT_W(CNT_W)) u_down (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (ctrl.enable),
        .refill_i (refill),
        .init_i   (start_count),
        .zero_o   (at_zero)
    );

    always_comb begin
        st_d       = st_q;
        st_d.armed = ctrl.enable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reset_req = st_q.armed && at_zero;

    // R5: inhibit blocks every refill
    assert_no_refill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        no_refill |-> !refill);

    // R3: once raised, the request holds while enabled
    assert_req_latched_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_req && wd_enable) |=> reset_req);

    // R1: disabling drops the request on the next edge
    assert_req_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_enable |=> !reset_req);

endmodule

// File: tb/sample_watchdog_bench.sv
module sample_watchdog_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;

    logic clk = 0, rst_n = 0;
    logic en = 0, inh = 0, stb = 0;
    logic [CW-1:0] init = '0;
    logic req;

    int n_checks = 0, n_fail = 0;
    int m_cnt = 0, m_ph = 0;
    bit m_arm = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sample_watchdog #(.CNT_W(CW), .PHASE_W(4)) u_sample_watchdog (
        .clk(clk), .rst_n(rst_n), .wd_enable(en), .no_refill(inh),
        .start_count(init), .sample_tick(stb), .reset_req(req)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: reset_req actual %0b expected %0b (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // One clock edge; reference model updated from the requirements
    task automatic step(input string tag);
        bit refill;
        @(posedge clk);
        #1;
        if (!en) begin
            m_cnt = int'(init); m_ph = 0; m_arm = 0;
        end else begin
            refill = stb && (m_ph == 15) && !inh;          // R4, R5
            if (m_cnt != 0) m_cnt = refill ? int'(init) : m_cnt - 1; // R2, R6, R3
            if (stb) m_ph = (m_ph + 1) % 16;
            m_arm = 1;
        end
        check(tag, req, m_arm && (m_cnt == 0));
    endtask

    task automatic run(input string tag, input int start, input int period,
                       input bit inhibit, input int cycles);
        en = 0; stb = 0; inh = inhibit; init = CW'(start);
        step("R1");
        step("R1");
        en = 1;
        for (int i = 0; i < cycles; i++) begin
            stb = ((i % period) == period - 1);
            step(tag);
        end
        stb = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++; n_checks++;
        $display("FAIL watchdog: run actual hung expected finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 3);
        check("R1", req, 1'b0);
        rst_n = 1;
        // R1: disabled with zero start count never requests reset
        init = '0;
        for (int i = 0; i < 20; i++) begin stb = i[0]; step("R1"); end
        // R8: zero start count trips after first enabled edge
        run("R8", 0, 1, 0, 4);
        // R2/R3: no strobes, trips at start count and stays
        run("R2", 9, 1000, 0, 30);
        // R6: 16 back-to-back strobes rescue a count of 16
        run("R6", 16, 1, 0, 100);
        check("R6", req, 1'b0);
        // R3: count 15 trips before the 16th strobe and stays latched
        run("R3", 15, 1, 0, 100);
        check("R3", req, 1'b1);
        // R5: inhibit lets count 40 run out despite strobes
        run("R5", 40, 1, 1, 60);
        check("R5", req, 1'b1);
        // R4/R5 sweep over start counts, strobe spacing and inhibit
        for (int s = 0; s <= 20; s++)
            for (int p = 1; p <= 3; p++)
                for (int h = 0; h < 2; h++)
                    run(h ? "R5" : "R4", s, p, h[0], 60);
        // R7: phase restarts after a one-edge disable
        run("R7", 30, 1, 0, 10);
        en = 0; step("R7");
        init = CW'(12); en = 0; step("R7");
        en = 1; stb = 1;
        for (int i = 0; i < 20; i++) step("R7");
        check("R7", req, 1'b1);
        stb = 0;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule